// File: doc/BRIEF.md
# Line-Operation Write-Back Data Cache

This block is a small direct-mapped data cache. It uses write-back and write-allocate, and it sits between a load/store unit and a word-wide memory port. The cache serves 64-bit loads and byte-masked stores. It also executes three maintenance commands, and each command acts on the one 64-byte line that holds the supplied address:

- **Discard** drops the line and never writes it back.
- **Clean** writes a modified line back and keeps it resident.
- **Flush** writes a modified line back and then drops it.

The requester presents one operation at a time with a valid/ready handshake. While the cache is busy, `req_ready` stays low. When the operation ends, the cache gives a one-cycle completion pulse with read data and a fault flag.

Line fills and write-backs each move eight 64-bit beats. Every beat is a separate valid/ready transfer on the memory side, and the beat addresses ascend from the line base. An address window set by parameters is uncacheable. Any access that falls in that window faults and has no effect.

A per-request write-permission input gates stores and all three maintenance commands. A load does not need that permission.

Top module: `lineop_dcache`

## Requirements
- R1: Operation codes on `req_op` are load=0, store=1, discard=2, clean=3, flush=4. A load that misses fetches its line in 8 read beats and then returns the addressed word. A load that hits returns the word with no memory traffic.
- R2: A store that hits merges only the bytes whose `req_wmask` bit is set (bit i covers data bits 8i+7..8i), marks the line modified and makes no memory traffic. A store that misses fills the line first. If the line it displaces is modified, that line is written back in 8 beats before the fill.
- R3: Discard clears the line's valid and modified state without any write-back, so a later load of that line returns the memory contents.
- R4: Clean of a modified resident line writes it back in 8 write beats. The line stays resident and unmodified, so a following load hits and a following discard writes nothing.
- R5: Flush of a resident line writes it back first if it is modified, then makes it non-resident, so the next load refetches it.
- R6: A maintenance command on a non-resident line, or a clean on an unmodified line, completes without fault and without memory traffic. `rsp_done` is high in the second cycle after acceptance. Discarding the same line twice is allowed.
- R7: A maintenance command changes only the addressed line. Other resident lines keep their data and their modified state.
- R8: An address with `(addr & UNC_MASK) == UNC_BASE` (defaults 0x8000_0000 for both) is uncacheable. Any operation to it completes with `rsp_fault`=1, no memory traffic and no change to cache state.
- R9: When `req_wperm`=0, a store or maintenance command faults with no effect and no traffic. A load is unaffected by `req_wperm`.
- R10: Maintenance commands ignore the byte-offset bits below the 64-byte line boundary.
- R11: `req_ready` is high only when idle and drops from acceptance until completion. `rsp_done` is a single-cycle pulse. A stalled beat holds its address and direction. Every completed operation moved a whole number of lines.
- R12: An operation code other than 0 to 4 completes with `rsp_fault`=1 and no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle, request accepted when both high |
| req_op | input | 3 | Operation code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Store data |
| req_wmask | input | 8 | Store byte enables |
| req_wperm | input | 1 | Write permission for this request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Operation faulted (valid with rsp_done) |
| rsp_rdata | output | 64 | Load result (valid with rsp_done) |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat is a write-back (1) or fill read (0) |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 64 | Write-back beat data |
| mem_rdata | input | 64 | Fill beat data, taken when mem_valid and mem_ready |

## Verification
Wrong valid or modified state has one of two effects at the ports. One is an unexpected read burst on the next load of that line. The other is a write burst that appears, or fails to appear, on the next clean, flush or eviction. The bench therefore follows each maintenance command with a load or a second command and counts memory beats of each direction. A dropped write-back leaves stale data in the memory model, and the bench reads that data straight back. A wrong fault decision shows in the same cycle as `rsp_done`. A misrouted line index shows as a neighbouring line that refetches or writes back when it should not.

// File: rtl/lineop_pkg.sv
package lineop_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_DROP  = 3'd2,
        OP_CLEAN = 3'd3,
        OP_FLUSH = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WBACK,
        ST_FILL,
        ST_DONE
    } state_e;

    typedef enum logic [2:0] {
        TC_NONE,
        TC_FILL,
        TC_MARK,
        TC_UNMARK,
        TC_DROP
    } tag_cmd_e;

    function automatic logic op_known(input logic [2:0] op);
        return op inside {OP_LOAD, OP_STORE, OP_DROP, OP_CLEAN, OP_FLUSH};
    endfunction

    function automatic logic op_writes(input logic [2:0] op);
        return op inside {OP_STORE, OP_DROP, OP_CLEAN, OP_FLUSH};
    endfunction

endpackage

// File: rtl/lineop_tag_store.sv
module lineop_tag_store
    import lineop_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  tag_cmd_e         cmd,
    input  logic [TAG_W-1:0] tag_in,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);

    logic [NUM_LINES-1:0] valid_vec;
    logic [NUM_LINES-1:0] dirty_vec;
    logic [TAG_W-1:0]     tag_arr [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic             sel;
        logic             v_q;
        logic             d_q;
        logic [TAG_W-1:0] t_q;

        assign sel = (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
            end else if (sel) begin
                case (cmd)
                    TC_FILL: begin
                        v_q <= 1'b1;
                        d_q <= 1'b0;
                        t_q <= tag_in;
                    end
                    TC_MARK:   d_q <= 1'b1;
                    TC_UNMARK: d_q <= 1'b0;
                    TC_DROP: begin
                        v_q <= 1'b0;
                        d_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end

        assign valid_vec[i] = v_q;
        assign dirty_vec[i] = d_q;
        assign tag_arr[i]   = t_q;
    end

    assign rd_valid = valid_vec[idx];
    assign rd_dirty = dirty_vec[idx];
    assign rd_tag   = tag_arr[idx];

endmodule

// File: rtl/lineop_data_store.sv
module lineop_data_store #(
    parameter int NUM_LINES = 8,
    parameter int WORDS     = 8,
    parameter int DATA_W    = 64,
    parameter int IDX_W     = 3,
    parameter int WSEL_W    = 3
) (
    input  logic                clk,
    input  logic [IDX_W-1:0]    idx,
    input  logic [WSEL_W-1:0]   r_word,
    output logic [DATA_W-1:0]   r_data,
    input  logic                we,
    input  logic [WSEL_W-1:0]   w_word,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_mask
);

    localparam int DEPTH = NUM_LINES * WORDS;
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] merged;

    assign r_data   = mem_q[{idx, r_word}];
    assign old_word = mem_q[{idx, w_word}];

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign merged[b*8 +: 8] = w_mask[b] ? w_data[b*8 +: 8] : old_word[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (we) mem_q[{idx, w_word}] <= merged;
    end

endmodule

// File: rtl/lineop_ctrl.sv
module lineop_ctrl
    import lineop_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 64,
    parameter int          WORDS     = 8,
    parameter int          IDX_W     = 3,
    parameter int          WSEL_W    = 3,
    parameter int          BSEL_W    = 3,
    parameter int          TAG_W     = 23,
    parameter logic [31:0] UNC_BASE  = 32'h8000_0000,
    parameter logic [31:0] UNC_MASK  = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_wmask,
    input  logic                req_wperm,
    output logic                rsp_done,
    output logic                rsp_fault,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [IDX_W-1:0]    line_idx,
    output tag_cmd_e            tag_cmd,
    output logic [TAG_W-1:0]    tag_wr,
    input  logic                tag_valid,
    input  logic                tag_dirty,
    input  logic [TAG_W-1:0]    tag_rd,
    output logic [WSEL_W-1:0]   d_rword,
    input  logic [DATA_W-1:0]   d_rdata,
    output logic                d_we,
    output logic [WSEL_W-1:0]   d_wword,
    output logic [DATA_W-1:0]   d_wdata,
    output logic [DATA_W/8-1:0] d_wmask
);

    localparam int OFF_W = WSEL_W + BSEL_W;

    state_e                state_q, state_d;
    logic [2:0]            op_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [DATA_W/8-1:0]   wmask_q;
    logic                  wperm_q;
    logic [WSEL_W-1:0]     beat_q, beat_d;
    logic [DATA_W-1:0]     rdata_q, rdata_d;
    logic                  fault_q, fault_d;

    logic [TAG_W-1:0]      req_tag;
    logic [WSEL_W-1:0]     req_word;
    logic                  hit;
    logic                  uncached;
    logic                  refused;
    logic                  last_beat;

    assign line_idx  = addr_q[OFF_W +: IDX_W];
    assign req_tag   = addr_q[ADDR_W-1 -: TAG_W];
    assign req_word  = addr_q[BSEL_W +: WSEL_W];
    assign hit       = tag_valid && (tag_rd == req_tag);
    assign uncached  = ((addr_q & ADDR_W'(UNC_MASK)) == ADDR_W'(UNC_BASE));
    assign refused   = uncached || !op_known(op_q) || (op_writes(op_q) && !wperm_q);
    assign last_beat = (beat_q == WSEL_W'(WORDS - 1));
    assign tag_wr    = req_tag;
    assign d_rword   = (state_q == ST_WBACK) ? beat_q : req_word;
    assign mem_wdata = d_rdata;

    always_comb begin
        state_d   = state_q;
        beat_d    = beat_q;
        rdata_d   = rdata_q;
        fault_d   = fault_q;
        tag_cmd   = TC_NONE;
        d_we      = 1'b0;
        d_wword   = req_word;
        d_wdata   = wdata_q;
        d_wmask   = wmask_q;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;

        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_CHECK;
                    fault_d = 1'b0;
                end
            end

            ST_CHECK: begin
                beat_d = '0;
                if (refused) begin
                    fault_d = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    case (op_q)
                        OP_LOAD, OP_STORE: begin
                            if (hit) begin
                                if (op_q == OP_STORE) begin
                                    d_we    = 1'b1;
                                    tag_cmd = TC_MARK;
                                end else begin
                                    rdata_d = d_rdata;
                                end
                                state_d = ST_DONE;
                            end else if (tag_valid && tag_dirty) begin
                                state_d = ST_WBACK;
                            end else begin
                                state_d = ST_FILL;
                            end
                        end
                        OP_DROP: begin
                            if (hit) tag_cmd = TC_DROP;
                            state_d = ST_DONE;
                        end
                        OP_CLEAN: begin
                            state_d = (hit && tag_dirty) ? ST_WBACK : ST_DONE;
                        end
                        default: begin
                            if (hit && tag_dirty) begin
                                state_d = ST_WBACK;
                            end else begin
                                if (hit) tag_cmd = TC_DROP;
                                state_d = ST_DONE;
                            end
                        end
                    endcase
                end
            end

            ST_WBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {tag_rd, line_idx, beat_q, {BSEL_W{1'b0}}};
                if (mem_ready) begin
                    beat_d = beat_q + WSEL_W'(1);
                    if (last_beat) begin
                        case (op_q)
                            OP_LOAD, OP_STORE: state_d = ST_FILL;
                            OP_CLEAN: begin
                                tag_cmd = TC_UNMARK;
                                state_d = ST_DONE;
                            end
                            default: begin
                                tag_cmd = TC_DROP;
                                state_d = ST_DONE;
                            end
                        endcase
                    end
                end
            end

            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {req_tag, line_idx, beat_q, {BSEL_W{1'b0}}};
                if (mem_ready) begin
                    d_we    = 1'b1;
                    d_wword = beat_q;
                    d_wdata = mem_rdata;
                    d_wmask = '1;
                    beat_d  = beat_q + WSEL_W'(1);
                    if (last_beat) begin
                        tag_cmd = TC_FILL;
                        state_d = ST_CHECK;
                    end
                end
            end

            ST_DONE: state_d = ST_IDLE;

            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wmask_q <= '0;
            wperm_q <= 1'b0;
            beat_q  <= '0;
            rdata_q <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            rdata_q <= rdata_d;
            fault_q <= fault_d;
            if (state_q == ST_IDLE && req_valid) begin
                op_q    <= req_op;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wmask_q <= req_wmask;
                wperm_q <= req_wperm;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_done  = (state_q == ST_DONE);
    assign rsp_fault = fault_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/lineop_dcache.sv
module lineop_dcache
    import lineop_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 64,
    parameter int          LINE_BYTES = 64,
    parameter int          NUM_LINES  = 8,
    parameter logic [31:0] UNC_BASE   = 32'h8000_0000,
    parameter logic [31:0] UNC_MASK   = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_wmask,
    input  logic                req_wperm,
    output logic                rsp_done,
    output logic                rsp_fault,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);

    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int WORDS_PER_LINE = LINE_BYTES / BYTES_PER_WORD;
    localparam int BSEL_W         = $clog2(BYTES_PER_WORD);
    localparam int WSEL_W         = $clog2(WORDS_PER_LINE);
    localparam int IDX_W          = $clog2(NUM_LINES);
    localparam int TAG_W          = ADDR_W - IDX_W - WSEL_W - BSEL_W;

    logic [IDX_W-1:0]          line_idx;
    tag_cmd_e                  tag_cmd;
    logic [TAG_W-1:0]          tag_wr;
    logic                      tag_valid;
    logic                      tag_dirty;
    logic [TAG_W-1:0]          tag_rd;
    logic [WSEL_W-1:0]         d_rword;
    logic [DATA_W-1:0]         d_rdata;
    logic                      d_we;
    logic [WSEL_W-1:0]         d_wword;
    logic [DATA_W-1:0]         d_wdata;
    logic [BYTES_PER_WORD-1:0] d_wmask;

    lineop_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WORDS    (WORDS_PER_LINE),
        .IDX_W    (IDX_W),
        .WSEL_W   (WSEL_W),
        .BSEL_W   (BSEL_W),
        .TAG_W    (TAG_W),
        .UNC_BASE (UNC_BASE),
        .UNC_MASK (UNC_MASK)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wmask (req_wmask),
        .req_wperm (req_wperm),
        .rsp_done  (rsp_done),
        .rsp_fault (rsp_fault),
        .rsp_rdata (rsp_rdata),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .line_idx  (line_idx),
        .tag_cmd   (tag_cmd),
        .tag_wr    (tag_wr),
        .tag_valid (tag_valid),
        .tag_dirty (tag_dirty),
        .tag_rd    (tag_rd),
        .d_rword   (d_rword),
        .d_rdata   (d_rdata),
        .d_we      (d_we),
        .d_wword   (d_wword),
        .d_wdata   (d_wdata),
        .d_wmask   (d_wmask)
    );

    lineop_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .idx      (line_idx),
        .cmd      (tag_cmd),
        .tag_in   (tag_wr),
        .rd_valid (tag_valid),
        .rd_dirty (tag_dirty),
        .rd_tag   (tag_rd)
    );

    lineop_data_store #(
        .NUM_LINES (NUM_LINES),
        .WORDS     (WORDS_PER_LINE),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .WSEL_W    (WSEL_W)
    ) u_data (
        .clk    (clk),
        .idx    (line_idx),
        .r_word (d_rword),
        .r_data (d_rdata),
        .we     (d_we),
        .w_word (d_wword),
        .w_data (d_wdata),
        .w_mask (d_wmask)
    );

endmodule

// File: rtl/lineop_dcache_chk.sv
module lineop_dcache_chk #(
    parameter int          ADDR_W   = 32,
    parameter int          WORDS    = 8,
    parameter logic [31:0] UNC_BASE = 32'h8000_0000,
    parameter logic [31:0] UNC_MASK = 32'h8000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_fault,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr
);

    logic [7:0] beats_q;

    always_ff @(posedge clk) begin
        if (rst)                         beats_q <= '0;
        else if (req_ready)              beats_q <= '0;
        else if (mem_valid && mem_ready) beats_q <= beats_q + 8'd1;
    end

    AST_BEATS_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !req_ready);                                            // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);                                              // R11
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                             // R11
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R11
    AST_WHOLE_LINES: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> ((beats_q % 8'(WORDS)) == 8'd0));                        // R11
    AST_NO_UNCACHED_BEAT: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ((mem_addr & ADDR_W'(UNC_MASK)) != ADDR_W'(UNC_BASE))); // R8
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault) |-> (beats_q == 8'd0));                       // R9

endmodule

bind lineop_dcache lineop_dcache_chk #(
    .ADDR_W   (ADDR_W),
    .WORDS    (WORDS_PER_LINE),
    .UNC_BASE (UNC_BASE),
    .UNC_MASK (UNC_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_fault (rsp_fault),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr)
);

// File: tb/lineop_dcache_test.sv
`timescale 1ns/1ps
module lineop_dcache_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_wmask = '0;
    logic        req_wperm = 1'b1;
    logic        rsp_done;
    logic        rsp_fault;
    logic [63:0] rsp_rdata;
    logic        mem_valid;
    logic        mem_ready;
    logic        mem_write;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata;

    always #2.5 clk = ~clk;

    lineop_dcache uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .req_wperm(req_wperm),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // backing memory: 512 words, with a periodic stall
    logic [63:0] mem [0:511];
    logic [1:0]  stall_q;
    int          rd_beats = 0;
    int          wr_beats = 0;

    function automatic logic [63:0] pat(input int i);
        return {32'hC0DE_0000 + 32'(i), 32'h5A5A_0000 + 32'(i)};
    endfunction

    assign mem_ready = (stall_q != 2'd3);
    assign mem_rdata = mem[mem_addr[11:3]];

    always @(posedge clk) begin
        if (rst) stall_q <= 2'd0;
        else     stall_q <= stall_q + 2'd1;
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                mem[mem_addr[11:3]] <= mem_wdata;
                wr_beats <= wr_beats + 1;
            end else begin
                rd_beats <= rd_beats + 1;
            end
        end
    end

    int          checks = 0;
    int          fails  = 0;
    logic [63:0] r_data;
    logic        r_fault;
    int          r_lat;
    int          r_rd;
    int          r_wr;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [31:0] addr,
                         input logic [63:0] wd, input logic [7:0] wm, input logic perm);
        int rd0;
        int wr0;
        @(negedge clk);
        rd0 = rd_beats;
        wr0 = wr_beats;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_wdata = wd;
        req_wmask = wm;
        req_wperm = perm;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        while (!rsp_done && r_lat < 400) begin
            @(negedge clk);
            r_lat++;
        end
        r_data  = rsp_rdata;
        r_fault = rsp_fault;
        r_rd    = rd_beats - rd0;
        r_wr    = wr_beats - wr0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 ready after reset", 64'(req_ready), 64'd1);
        chk("R11 no done after reset", 64'(rsp_done), 64'd0);
        chk("R11 no beat after reset", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_load;
        do_op(3'd0, 32'h008, '0, 8'h00, 1'b1);
        chk("R1 miss data", r_data, pat(1));
        chk("R1 miss reads", 64'(r_rd), 64'd8);
        chk("R1 miss writes", 64'(r_wr), 64'd0);
        do_op(3'd0, 32'h010, '0, 8'h00, 1'b1);
        chk("R1 hit data", r_data, pat(2));
        chk("R1 hit reads", 64'(r_rd), 64'd0);
    endtask

    task automatic t_store;
        do_op(3'd1, 32'h018, 64'h1111_2222_3333_4444, 8'h0F, 1'b1);
        chk("R2 hit traffic", 64'(r_rd + r_wr), 64'd0);
        do_op(3'd0, 32'h018, '0, 8'h00, 1'b1);
        chk("R2 byte merge", r_data, {pat(3)[63:32], 32'h3333_4444});
        do_op(3'd1, 32'h048, 64'hAAAA_0000_0000_0048, 8'hFF, 1'b1);
        chk("R2 allocate reads", 64'(r_rd), 64'd8);
        do_op(3'd0, 32'h048, '0, 8'h00, 1'b1);
        chk("R2 allocated data", r_data, 64'hAAAA_0000_0000_0048);
    endtask

    task automatic t_drop;
        do_op(3'd2, 32'h000, '0, 8'h00, 1'b1);
        chk("R3 discard writes", 64'(r_wr), 64'd0);
        chk("R3 discard fault", 64'(r_fault), 64'd0);
        do_op(3'd0, 32'h018, '0, 8'h00, 1'b1);
        chk("R3 stale data back", r_data, pat(3));
        chk("R3 refetch reads", 64'(r_rd), 64'd8);
    endtask

    task automatic t_clean;
        do_op(3'd3, 32'h040, '0, 8'h00, 1'b1);
        chk("R4 clean writes", 64'(r_wr), 64'd8);
        chk("R4 memory updated", mem[9], 64'hAAAA_0000_0000_0048);
        do_op(3'd0, 32'h048, '0, 8'h00, 1'b1);
        chk("R4 still resident", 64'(r_rd), 64'd0);
        do_op(3'd3, 32'h040, '0, 8'h00, 1'b1);
        chk("R6 clean unmodified writes", 64'(r_wr), 64'd0);
        chk("R6 clean unmodified latency", 64'(r_lat), 64'd2);
        do_op(3'd2, 32'h040, '0, 8'h00, 1'b1);
        chk("R4 no longer modified", 64'(r_wr), 64'd0);
        do_op(3'd0, 32'h048, '0, 8'h00, 1'b1);
        chk("R4 refetched value", r_data, 64'hAAAA_0000_0000_0048);
    endtask

    task automatic t_flush;
        do_op(3'd1, 32'h088, 64'hBBBB_0000_0000_0088, 8'hFF, 1'b1);
        do_op(3'd4, 32'h080, '0, 8'h00, 1'b1);
        chk("R5 flush writes", 64'(r_wr), 64'd8);
        chk("R5 memory updated", mem[17], 64'hBBBB_0000_0000_0088);
        do_op(3'd0, 32'h088, '0, 8'h00, 1'b1);
        chk("R5 refetch reads", 64'(r_rd), 64'd8);
        chk("R5 refetch data", r_data, 64'hBBBB_0000_0000_0088);
        do_op(3'd4, 32'h080, '0, 8'h00, 1'b1);
        chk("R5 clean line flush writes", 64'(r_wr), 64'd0);
        do_op(3'd0, 32'h080, '0, 8'h00, 1'b1);
        chk("R5 clean line dropped", 64'(r_rd), 64'd8);
    endtask

    task automatic t_absent;
        for (int k = 0; k < 4; k++) begin
            logic [2:0] op;
            op = (k == 3) ? 3'd4 : ((k == 2) ? 3'd3 : 3'd2);
            do_op(op, 32'h0C0, '0, 8'h00, 1'b1);
            chk("R6 absent latency", 64'(r_lat), 64'd2);
            chk("R6 absent fault", 64'(r_fault), 64'd0);
            chk("R6 absent traffic", 64'(r_rd + r_wr), 64'd0);
        end
    endtask

    task automatic t_adjacent;
        do_op(3'd1, 32'h100, 64'h1234_0000_0000_0100, 8'hFF, 1'b1);
        do_op(3'd1, 32'h140, 64'h5678_0000_0000_0140, 8'hFF, 1'b1);
        do_op(3'd2, 32'h100, '0, 8'h00, 1'b1);
        do_op(3'd0, 32'h140, '0, 8'h00, 1'b1);
        chk("R7 neighbour data", r_data, 64'h5678_0000_0000_0140);
        chk("R7 neighbour resident", 64'(r_rd), 64'd0);
        do_op(3'd4, 32'h140, '0, 8'h00, 1'b1);
        chk("R7 neighbour still modified", 64'(r_wr), 64'd8);
        chk("R7 neighbour written", mem[40], 64'h5678_0000_0000_0140);
        do_op(3'd0, 32'h100, '0, 8'h00, 1'b1);
        chk("R7 target dropped", r_data, pat(32));
    endtask

    task automatic t_victim;
        do_op(3'd1, 32'h180, 64'hCCCC_0000_0000_0180, 8'hFF, 1'b1);
        do_op(3'd0, 32'h380, '0, 8'h00, 1'b1);
        chk("R2 victim writes", 64'(r_wr), 64'd8);
        chk("R2 victim reads", 64'(r_rd), 64'd8);
        chk("R2 victim data saved", mem[48], 64'hCCCC_0000_0000_0180);
        chk("R2 new line data", r_data, pat(112));
    endtask

    task automatic t_uncached;
        do_op(3'd2, 32'h8000_0380, '0, 8'h00, 1'b1);
        chk("R8 uncached fault", 64'(r_fault), 64'd1);
        chk("R8 uncached traffic", 64'(r_rd + r_wr), 64'd0);
        do_op(3'd0, 32'h8000_0000, '0, 8'h00, 1'b1);
        chk("R8 uncached load fault", 64'(r_fault), 64'd1);
        do_op(3'd0, 32'h380, '0, 8'h00, 1'b1);
        chk("R8 cache state kept", 64'(r_rd), 64'd0);
    endtask

    task automatic t_perm;
        do_op(3'd1, 32'h380, 64'hDDDD_0000_0000_0380, 8'hFF, 1'b1);
        do_op(3'd1, 32'h380, 64'hEEEE_0000_0000_0380, 8'hFF, 1'b0);
        chk("R9 store fault", 64'(r_fault), 64'd1);
        do_op(3'd0, 32'h380, '0, 8'h00, 1'b0);
        chk("R9 load allowed", 64'(r_fault), 64'd0);
        chk("R9 store had no effect", r_data, 64'hDDDD_0000_0000_0380);
        do_op(3'd3, 32'h380, '0, 8'h00, 1'b0);
        chk("R9 clean fault", 64'(r_fault), 64'd1);
        chk("R9 clean no traffic", 64'(r_wr), 64'd0);
        do_op(3'd2, 32'h380, '0, 8'h00, 1'b0);
        chk("R9 discard fault", 64'(r_fault), 64'd1);
        do_op(3'd4, 32'h380, '0, 8'h00, 1'b1);
        chk("R9 line still modified", 64'(r_wr), 64'd8);
        chk("R9 data written", mem[112], 64'hDDDD_0000_0000_0380);
    endtask

    task automatic t_offset;
        do_op(3'd1, 32'h1C0, 64'hF0F0_0000_0000_01C0, 8'hFF, 1'b1);
        do_op(3'd2, 32'h1ED, '0, 8'h00, 1'b1);
        chk("R10 offset discard fault", 64'(r_fault), 64'd0);
        do_op(3'd0, 32'h1C0, '0, 8'h00, 1'b1);
        chk("R10 line dropped", r_data, pat(56));
        chk("R10 refetch reads", 64'(r_rd), 64'd8);
    endtask

    task automatic t_badop;
        do_op(3'd7, 32'h000, '0, 8'hFF, 1'b1);
        chk("R12 unknown op fault", 64'(r_fault), 64'd1);
        chk("R12 unknown op traffic", 64'(r_rd + r_wr), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = pat(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_store();
        t_drop();
        t_clean();
        t_flush();
        t_absent();
        t_adjacent();
        t_victim();
        t_uncached();
        t_perm();
        t_offset();
        t_badop();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule